// File: doc/BRIEF.md
# Serial Highway Monitor and Signaling Engine

This block attaches one device to a time-division serial highway in which a frame of 256 bit periods starts at each `fsync` pulse. The frame holds eight 32-bit subframes, and three static strap inputs pick the one the device uses. Inside that subframe the block reads the downstream monitor byte, the downstream signaling byte and its two handshake bits. In the same bit positions it drives the upstream monitor byte, the upstream signaling code and its own handshake bits. All other bit periods are left undriven.

A host reaches a small internal register file through the monitor channel. Bytes move one per two frames under an MX/MR acknowledge handshake, where both bits are active low. A message is a command byte, a start address and, for writes, the data. The address steps after every register access. A read message makes the block stream bytes back under the same handshake. Handshake violations, collisions and malformed messages are reported with an abort. The same subframe also carries two 3-bit mode codes to the device, one per channel, and the block filters them before use. The block sends its own upstream status code on the signaling byte.

Top module: `gci_monitor_engine`

## Requirements
- R1: Only the subframe whose index (frame bit period / 32) equals `strap` is used. Within it, bit periods 16..23 carry the monitor byte MSB first, 24..29 carry the 6-bit C/I code MSB first, 30 carries MR and 31 carries MX. `txEn` is high in exactly those 16 periods of each frame, and traffic in other subframes has no effect.
- R2: When no transmission is active, the upstream monitor byte is 0xFF and upstream MX and MR are both 1 (inactive).
- R3: A downstream byte counts as received when MX is 0 in a frame after a frame with MX 1. The block acknowledges it by driving upstream MR to 0 in the next frame only.
- R4: A message whose first byte has upper nibble 0xA writes its third and later bytes to consecutive registers, starting at the address in the second byte and wrapping modulo the register count.
- R5: A message whose first byte is 0xB plus n (n = 0..15) returns n+1 bytes from consecutive registers, starting at the address in the second byte. Each byte is sent with upstream MX 0 for one frame, followed by a frame with MX 1 and data 0xFF. The host must acknowledge with downstream MR 0 in that second frame.
- R6: Downstream MX at 1 for two consecutive frames after a received byte ends the message, and a complete read message starts its reply in the next frame.
- R7: An abort drives upstream MR to 0 for exactly two consecutive frames and discards the message. It is raised for: MX held at 0 for two frames, an unknown command nibble, a message ending before its address byte, a missing acknowledge during a read reply, and a downstream MX of 0 while a reply byte is outstanding.
- R8: A downstream C/I code is applied only after it arrives unchanged in two consecutive frames. `ciModeA` takes code bits 5..3 and `ciModeB` takes bits 2..0.
- R9: An upstream C/I value, sampled from `ciUp` at the end of the subframe, is sent for at least two consecutive frames before a new value replaces it.
- R10: After reset, `txEn` stays 0 until the first `fsync`, both modes read 0, and the upstream C/I code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one highway bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High during bit period 0 of each frame |
| strap | input | 3 | Static subframe selection |
| rxBit | input | 1 | Downstream serial data |
| ciUp | input | 6 | Upstream signaling code to send |
| txBit | output | 1 | Upstream serial data |
| txEn | output | 1 | Upstream data valid (drive enable) |
| ciModeA | output | 3 | Filtered mode code for channel A |
| ciModeB | output | 3 | Filtered mode code for channel B |

## Verification
The bench goes after the frame boundaries of each handshake. A design that acknowledges one frame late, or holds the acknowledge for two frames, would look exactly like an abort. A reply that starts before the end-of-message pair would collide with the host. Each abort cause is driven on its own, and the bench counts the abort frames: a block that raises MR for only one frame would be read as a plain acknowledge. A write that runs past the last register tests whether the address wraps. The mode filter gets a single glitched frame, which a design without the two-frame check would apply. The upstream code is changed one frame after an update, which a design without the hold would send at once.

// File: rtl/gci_pkg.sv
package gci_pkg;
  // command nibbles in the first monitor byte
  localparam logic [3:0] CMD_WRITE = 4'hA;
  localparam logic [3:0] CMD_READ  = 4'hB;

  typedef enum logic [1:0] {RX_IDLE, RX_GOT, RX_GAP, RX_WAITREL} rx_phase_t;

  // control -> datapath strobes, valid in the slot-done cycle
  typedef struct packed {
    logic wrEn;
    logic addrLoad;
    logic addrInc;
  } mon_strobe_t;
endpackage

// File: rtl/gci_datapath.sv
module gci_datapath
  import gci_pkg::*;
#(
  parameter int SUB_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsync,
  input  logic [SUB_W-1:0]  strap,
  input  logic              rxBit,
  input  logic [5:0]        ciUp,
  input  mon_strobe_t       strobe,
  input  logic [7:0]        upMon,
  input  logic              upMx,
  input  logic              upMr,
  output logic              txBit,
  output logic              txEn,
  output logic              slotDone,
  output logic [7:0]        rxMon,
  output logic              rxMx,
  output logic              rxMr,
  output logic [7:0]        rdData,
  output logic [2:0]        ciModeA,
  output logic [2:0]        ciModeB
);
  localparam int CNT_W = SUB_W + 5;
  localparam int REGS  = 1 << ADDR_W;

  logic [CNT_W-1:0] bitCnt, pos;
  logic             synced, live, inSlot;
  logic [4:0]       sub;
  logic [7:0]       monSr, scSr;
  logic [5:0]       prevCi, modeReg, upCi;
  logic [1:0]       sentCnt;
  logic [7:0]       regs [REGS];
  logic [ADDR_W-1:0] addr;

  // frame position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      synced <= 1'b0;
    end else if (fsync) begin
      bitCnt <= CNT_W'(1);
      synced <= 1'b1;
    end else if (synced) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign pos    = fsync ? '0 : bitCnt;
  assign live   = fsync | synced;
  assign sub    = pos[4:0];
  assign inSlot = live && (pos[CNT_W-1:5] == strap);
  assign txEn   = inSlot && sub[4];

  // downstream capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      monSr    <= 8'hFF;
      scSr     <= 8'hFF;
      slotDone <= 1'b0;
    end else begin
      slotDone <= inSlot && (sub == 5'd31);
      if (txEn && !sub[3]) monSr <= {monSr[6:0], rxBit};
      if (txEn &&  sub[3]) scSr  <= {scSr[6:0], rxBit};
    end
  end

  assign rxMon = monSr;
  assign rxMr  = scSr[1];
  assign rxMx  = scSr[0];

  // C/I filter and upstream C/I hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCi  <= '0;
      modeReg <= '0;
      upCi    <= '0;
      sentCnt <= 2'd2;
    end else if (slotDone) begin
      prevCi <= scSr[7:2];
      if (scSr[7:2] == prevCi) modeReg <= scSr[7:2];
      if (sentCnt == 2'd2 && ciUp != upCi) begin
        upCi    <= ciUp;
        sentCnt <= 2'd1;
      end else if (sentCnt != 2'd2) begin
        sentCnt <= sentCnt + 1'b1;
      end
    end
  end

  assign ciModeA = modeReg[5:3];
  assign ciModeB = modeReg[2:0];

  // register file with auto-incrementing address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
      addr <= '0;
    end else begin
      if (strobe.wrEn) regs[addr] <= monSr;
      if (strobe.addrLoad)     addr <= monSr[ADDR_W-1:0];
      else if (strobe.addrInc) addr <= addr + 1'b1;
    end
  end

  assign rdData = regs[addr];

  // upstream serializer
  always_comb begin
    txBit = 1'b1;
    if (txEn) begin
      if (!sub[3])            txBit = upMon[3'(5'd23 - sub)];
      else if (sub < 5'd30)   txBit = upCi[3'(5'd29 - sub)];
      else if (sub == 5'd30)  txBit = upMr;
      else                    txBit = upMx;
    end
  end

  a_r1_done_after_slot: assert property (@(posedge clk) disable iff (!rstN)
    slotDone |-> $past(txEn));
  a_r4_write_at_slot_end: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> slotDone);
  a_r8_mode_change_after_slot: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeReg) |-> $past(slotDone));
  a_r9_upci_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(upCi) |-> $past(sentCnt == 2'd2));
endmodule

// File: rtl/gci_ctrl.sv
module gci_ctrl
  import gci_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        slotDone,
  input  logic [7:0]  rxMon,
  input  logic        rxMx,
  input  logic        rxMr,
  input  logic [7:0]  rdData,
  output mon_strobe_t strobe,
  output logic [7:0]  upMon,
  output logic        upMx,
  output logic        upMr
);
  rx_phase_t  rxPh, nxtRx;
  logic       txMode, txChk;
  logic [1:0] byteIdx, abortCnt;
  logic [7:0] cmdReg;
  logic [3:0] txLeft;
  logic       mxAct, mrAct;
  logic       acceptByte, abortNow, startTx, txToChk, txAdvance, txDone;

  assign mxAct = !rxMx;
  assign mrAct = !rxMr;

  always_comb begin
    strobe     = '0;
    nxtRx      = rxPh;
    acceptByte = 1'b0;
    abortNow   = 1'b0;
    startTx    = 1'b0;
    txToChk    = 1'b0;
    txAdvance  = 1'b0;
    txDone     = 1'b0;
    if (slotDone) begin
      if (!txMode) begin
        case (rxPh)
          RX_IDLE:    if (mxAct) acceptByte = 1'b1;
          RX_GOT:     if (mxAct) abortNow = 1'b1; else nxtRx = RX_GAP;
          RX_GAP: begin
            if (mxAct)                       acceptByte = 1'b1;
            else if (byteIdx < 2'd2)         abortNow = 1'b1;
            else if (cmdReg[7:4] == CMD_READ) startTx = 1'b1;
            else                             nxtRx = RX_IDLE;
          end
          default:    if (!mxAct) nxtRx = RX_IDLE;
        endcase
        if (acceptByte) begin
          nxtRx = RX_GOT;
          case (byteIdx)
            2'd0: if (rxMon[7:4] != CMD_WRITE && rxMon[7:4] != CMD_READ) abortNow = 1'b1;
            2'd1: strobe.addrLoad = 1'b1;
            default: begin
              if (cmdReg[7:4] == CMD_READ) abortNow = 1'b1;
              else begin
                strobe.wrEn    = 1'b1;
                strobe.addrInc = 1'b1;
              end
            end
          endcase
        end
        if (startTx) begin
          strobe.addrInc = 1'b1;
          nxtRx = RX_IDLE;
        end
      end else begin
        if (mxAct)              abortNow = 1'b1;
        else if (!txChk)        txToChk = 1'b1;
        else if (!mrAct)        abortNow = 1'b1;
        else if (txLeft == 4'd0) txDone = 1'b1;
        else begin
          txAdvance      = 1'b1;
          strobe.addrInc = 1'b1;
        end
      end
      if (abortNow) begin
        strobe.wrEn    = 1'b0;
        strobe.addrLoad = 1'b0;
        strobe.addrInc = 1'b0;
        nxtRx = mxAct ? RX_WAITREL : RX_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPh     <= RX_IDLE;
      txMode   <= 1'b0;
      txChk    <= 1'b0;
      byteIdx  <= '0;
      abortCnt <= '0;
      cmdReg   <= '0;
      txLeft   <= '0;
      upMon    <= 8'hFF;
      upMx     <= 1'b1;
      upMr     <= 1'b1;
    end else if (slotDone) begin
      rxPh <= nxtRx;
      if (acceptByte && !abortNow) begin
        if (byteIdx == 2'd0) cmdReg <= rxMon;
        if (byteIdx != 2'd2) byteIdx <= byteIdx + 1'b1;
      end else if (nxtRx == RX_IDLE || nxtRx == RX_WAITREL) begin
        byteIdx <= '0;
      end
      if (abortNow) begin
        abortCnt <= 2'd1;
        upMr     <= 1'b0;
      end else if (abortCnt != 2'd0) begin
        abortCnt <= abortCnt - 1'b1;
        upMr     <= 1'b0;
      end else begin
        upMr <= !acceptByte;
      end
      if (startTx) begin
        txMode <= 1'b1;
        txChk  <= 1'b0;
        txLeft <= cmdReg[3:0];
        upMon  <= rdData;
        upMx   <= 1'b0;
      end
      if (txToChk) begin
        txChk <= 1'b1;
        upMon <= 8'hFF;
        upMx  <= 1'b1;
      end
      if (txAdvance) begin
        txChk  <= 1'b0;
        txLeft <= txLeft - 1'b1;
        upMon  <= rdData;
        upMx   <= 1'b0;
      end
      if (txDone) txMode <= 1'b0;
      if (abortNow) begin
        txMode <= 1'b0;
        upMon  <= 8'hFF;
        upMx   <= 1'b1;
      end
    end
  end

  a_r2_idle_monitor: assert property (@(posedge clk) disable iff (!rstN)
    (upMon != 8'hFF) |-> !upMx);
  a_r5_mx_only_in_reply: assert property (@(posedge clk) disable iff (!rstN)
    !upMx |-> txMode);
  a_r4_load_or_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEn, strobe.addrLoad}));
  a_r3_strobes_at_slot_end: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addrLoad || strobe.addrInc) |-> slotDone);
endmodule

// File: rtl/gci_monitor_engine.sv
module gci_monitor_engine
  import gci_pkg::*;
#(
  parameter int SUB_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fsync,
  input  logic [SUB_W-1:0] strap,
  input  logic             rxBit,
  input  logic [5:0]       ciUp,
  output logic             txBit,
  output logic             txEn,
  output logic [2:0]       ciModeA,
  output logic [2:0]       ciModeB
);
  mon_strobe_t strobe;
  logic [7:0]  upMon, rxMon, rdData;
  logic        upMx, upMr, rxMx, rxMr, slotDone;

  gci_datapath #(.SUB_W(SUB_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .fsync(fsync), .strap(strap), .rxBit(rxBit),
    .ciUp(ciUp), .strobe(strobe), .upMon(upMon), .upMx(upMx), .upMr(upMr),
    .txBit(txBit), .txEn(txEn), .slotDone(slotDone), .rxMon(rxMon),
    .rxMx(rxMx), .rxMr(rxMr), .rdData(rdData), .ciModeA(ciModeA),
    .ciModeB(ciModeB)
  );

  gci_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .slotDone(slotDone), .rxMon(rxMon),
    .rxMx(rxMx), .rxMr(rxMr), .rdData(rdData), .strobe(strobe),
    .upMon(upMon), .upMx(upMx), .upMr(upMr)
  );
endmodule

// File: tb/sim_gci_monitor_engine.sv
module sim_gci_monitor_engine;
  localparam logic [2:0] STRAP = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fsync = 1'b0;
  logic rxBit = 1'b1;
  logic [2:0] strap = STRAP;
  logic [5:0] ciUp = '0;
  logic txBit, txEn;
  logic [2:0] ciModeA, ciModeB;
  int nChecks = 0;
  int nFails = 0;
  logic [7:0] capMon, capSc;

  always #4 clk = ~clk;

  gci_monitor_engine u0 (
    .clk(clk), .rstN(rstN), .fsync(fsync), .strap(strap), .rxBit(rxBit),
    .ciUp(ciUp), .txBit(txBit), .txEn(txEn), .ciModeA(ciModeA), .ciModeB(ciModeB)
  );

  // {downMon, downSc, expUpMon, expUpSc}; Sc = {ci[5:0], MR, MX}
  localparam logic [31:0] VEC [20] = '{
    32'hFF03FF03,  // idle (R2)
    32'hA002FF03,  // write command (R4)
    32'hFF03FF01,  // ack (R3)
    32'h0302FF03,  // address 3
    32'hFF03FF01,
    32'h5A02FF03,  // data -> reg3
    32'hFF03FF01,
    32'hC302FF03,  // data -> reg4
    32'hFF03FF01,
    32'hFF03FF03,  // end of message (R6)
    32'hB102FF03,  // read two bytes (R5)
    32'hFF03FF01,
    32'h0302FF03,
    32'hFF03FF01,
    32'hFF03FF03,  // end of message, reply follows
    32'hFF035A02,  // first reply byte
    32'hFF01FF03,  // host ack
    32'hFF03C302,  // second reply byte
    32'hFF01FF03,  // host ack
    32'hFF03FF03   // idle again
  };

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int slotSel, input logic [7:0] mon, input logic [7:0] sc);
    int enCnt = 0;
    int badEn = 0;
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      fsync = (b == 0);
      if (b / 32 == slotSel && b % 32 >= 16)
        rxBit = (b % 32 < 24) ? mon[23 - b % 32] : sc[31 - b % 32];
      else
        rxBit = 1'b1;
      #1;
      if (txEn) begin
        enCnt++;
        if (!(b / 32 == int'(STRAP) && b % 32 >= 16)) badEn++;
      end
      if (b / 32 == int'(STRAP) && b % 32 >= 16) begin
        if (b % 32 < 24) capMon[23 - b % 32] = txBit;
        else             capSc[31 - b % 32] = txBit;
      end
    end
    check(enCnt == 16 && badEn == 0, "R1", "txEn window", enCnt, 16);
  endtask

  task automatic frame(input int slotSel, input logic [7:0] mon, input logic [7:0] sc,
                       input logic [7:0] expMon, input logic [7:0] expSc, input string req);
    run_frame(slotSel, mon, sc);
    check(capMon == expMon, req, "upstream monitor", capMon, expMon);
    check(capSc == expSc, req, "upstream signaling", capSc, expSc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R10: no output before the first frame pulse, modes cleared
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      check(!txEn, "R10", "txEn before fsync", txEn, 0);
    end
    check(ciModeA == 3'd0 && ciModeB == 3'd0, "R10", "modes after reset", {ciModeA, ciModeB}, 0);

    // main table: write 5A,C3 at 3..4 then read them back (R3 R4 R5 R6)
    for (int i = 0; i < 20; i++)
      frame(int'(STRAP), VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], "R3/R4/R5");

    // R7: MX held active two frames -> ack, then two abort frames
    frame(5, 8'hA0, 8'h02, 8'hFF, 8'h03, "R7");
    frame(5, 8'hA0, 8'h02, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R7");
    // R7: unknown command nibble
    frame(5, 8'h55, 8'h02, 8'hFF, 8'h03, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R7");
    // R7: message ends before its address
    frame(5, 8'hA0, 8'h02, 8'hFF, 8'h03, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R7");
    // R5/R7: one-byte read of reg4, host withholds the acknowledge
    frame(5, 8'hB0, 8'h02, 8'hFF, 8'h03, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R5");
    frame(5, 8'h04, 8'h02, 8'hFF, 8'h03, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R6");
    frame(5, 8'hFF, 8'h03, 8'hC3, 8'h02, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R7");
    // R7: host drives MX while a reply byte is outstanding
    frame(5, 8'hB0, 8'h02, 8'hFF, 8'h03, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'h03, 8'h02, 8'hFF, 8'h03, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R7");
    frame(5, 8'hFF, 8'h02, 8'h5A, 8'h02, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R7");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R7");
    // R4: write 11,22 at address F wraps to 0; read back via R5
    frame(5, 8'hA0, 8'h02, 8'hFF, 8'h03, "R4");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R4");
    frame(5, 8'h0F, 8'h02, 8'hFF, 8'h03, "R4");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R4");
    frame(5, 8'h11, 8'h02, 8'hFF, 8'h03, "R4");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R4");
    frame(5, 8'h22, 8'h02, 8'hFF, 8'h03, "R4");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R4");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R6");
    frame(5, 8'hB1, 8'h02, 8'hFF, 8'h03, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R5");
    frame(5, 8'h0F, 8'h02, 8'hFF, 8'h03, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h01, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R6");
    frame(5, 8'hFF, 8'h03, 8'h11, 8'h02, "R4");
    frame(5, 8'hFF, 8'h01, 8'hFF, 8'h03, "R5");
    frame(5, 8'hFF, 8'h03, 8'h22, 8'h02, "R4");
    frame(5, 8'hFF, 8'h01, 8'hFF, 8'h03, "R5");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R2");
    // R1: a command in another subframe is ignored (no ack)
    frame(2, 8'hA0, 8'h02, 8'hFF, 8'h03, "R1");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R1");

    // R8: code 101_011 needs two frames; glitch is ignored
    frame(5, 8'hFF, 8'hAF, 8'hFF, 8'h03, "R8");
    check(ciModeA == 3'd0 && ciModeB == 3'd0, "R8", "modes after one frame", {ciModeA, ciModeB}, 0);
    frame(5, 8'hFF, 8'hAF, 8'hFF, 8'h03, "R8");
    check(ciModeA == 3'd5 && ciModeB == 3'd3, "R8", "modes after two frames", {ciModeA, ciModeB}, 6'o53);
    frame(5, 8'hFF, 8'hFF, 8'hFF, 8'h03, "R8");
    check(ciModeA == 3'd5 && ciModeB == 3'd3, "R8", "modes after glitch", {ciModeA, ciModeB}, 6'o53);
    frame(5, 8'hFF, 8'h5B, 8'hFF, 8'h03, "R8");
    check(ciModeA == 3'd5 && ciModeB == 3'd3, "R8", "modes after first new", {ciModeA, ciModeB}, 6'o53);
    frame(5, 8'hFF, 8'h5B, 8'hFF, 8'h03, "R8");
    check(ciModeA == 3'd2 && ciModeB == 3'd6, "R8", "modes after second new", {ciModeA, ciModeB}, 6'o26);

    // R9: upstream code held two frames before it may change
    ciUp = 6'h2A;
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h03, "R9");
    ciUp = 6'h15;
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'hAB, "R9");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'hAB, "R9");
    frame(5, 8'hFF, 8'h03, 8'hFF, 8'h57, "R9");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule